// File: doc/BRIEF.md
# Parallel EEPROM Byte Write Controller

This block is the device side of a byte-wide parallel EEPROM write port. It watches three active-low asynchronous strobes (chip enable, write enable and output enable) together with an address bus and an 8-bit data bus. A write can be controlled by the chip enable or by the write enable, and the two styles give the same result. The address is taken when the later of the two enables falls, and the data is taken when the first of them rises.

Once the data is taken, the block runs a self-timed programming interval of a parameterised number of clock cycles. While this interval runs, it holds a busy output and ignores further strobes. During the interval the data output returns a polling status byte. At the end, the byte is committed to a small internal storage array, and the data output then shows the stored byte at the presented address.

The strobes pass through a two-flop synchronizer and are judged on their synchronized levels and edges. A host may pull output enable low while a write window is open. Doing so cancels the write.

Top module: `byte_store_writer`

## Requirements
- R1: While rstN is low and in the first cycle after it, busy is 0 and dataOut is 0x00. Every storage location resets to 0x00.
- R2: A write window opens only at a synchronized falling edge of chipEnN or wrEnN that leaves both low while outEnN is high. Each strobe reaches the control through two flops, and its edge acts at the third rising clock edge after the pin changes. Enables that fall while outEnN is low never cause a write, even if outEnN later returns high.
- R3: The address is sampled from addrIn when the window opens, which is at the later of the two falling enables. Changes to addrIn later in the window have no effect.
- R4: The data is sampled from dataIn at the first synchronized rising edge of either enable. Changes to dataIn later in the window have no effect.
- R5: busy rises in the cycle after the data is sampled. It stays high for exactly PROG_CYCLES clock cycles.
- R6: While busy is high, dataOut (registered, one cycle behind) is the inverse of bit 7 of the pending byte in bit 7, with bits 6..0 at zero.
- R7: When busy falls, the pending byte is in storage at the captured address. While idle, dataOut shows storage[addrIn] one clock after addrIn is presented.
- R8: If outEnN is low while a window is open, the window closes without busy rising, and storage is unchanged.
- R9: Strobe activity while busy is ignored. A new write needs a fresh falling enable after busy has dropped.
- R10: A write controlled by the chip enable and a write controlled by the write enable store identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Active-low chip enable, asynchronous |
| wrEnN | input | 1 | Active-low write enable, asynchronous |
| outEnN | input | 1 | Active-low output enable, asynchronous |
| addrIn | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Polling status while busy, otherwise the stored byte at addrIn |
| busy | output | 1 | High during the self-timed programming interval |

## Verification
Two events can meet in the same cycle. The first is the abort by output enable, and the second is the data capture on a rising enable. When both are seen together in an open window, the abort must win. The bench also provokes strobe pulses that fall inside the busy interval, including pulses that end near the commit. It judges both cases with a cycle-by-cycle reference model of the synchronizer delay and the write sequence. It then reads storage back through dataOut to confirm that only the intended byte changed.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int IDX_CE = 0;
  localparam int IDX_WE = 1;
  localparam int IDX_OE = 2;
  localparam int NUM_STROBES = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } bswState_t;

  typedef struct packed {
    logic capAddr;
    logic capData;
    logic commit;
  } bswStrobes_t;
endpackage

// File: rtl/bsw_sync.sv
module bsw_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawN,
  output logic [WIDTH-1:0] lvlN,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] stage1, stage2, prevS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '1;
      stage2 <= '1;
      prevS  <= '1;
    end else begin
      stage1 <= rawN;
      stage2 <= stage1;
      prevS  <= stage2;
    end
  end

  assign lvlN = stage2;
  assign fall = prevS & ~stage2;
  assign rise = ~prevS & stage2;
endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
#(
  parameter int PROG_CYCLES = 300000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STROBES-1:0] lvlN,
  input  logic [NUM_STROBES-1:0] fall,
  input  logic [NUM_STROBES-1:0] rise,
  output bswStrobes_t            strb,
  output logic                   busy,
  output logic                   armed
);
  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  bswState_t state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic enFall, enRise, bothLow, oeHigh;

  assign enFall  = fall[IDX_CE] | fall[IDX_WE];
  assign enRise  = rise[IDX_CE] | rise[IDX_WE];
  assign bothLow = ~lvlN[IDX_CE] & ~lvlN[IDX_WE];
  assign oeHigh  = lvlN[IDX_OE];

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (enFall && bothLow && oeHigh) begin
        stateNext    = ST_ARMED;
        strb.capAddr = 1'b1;
      end
      ST_ARMED: if (!oeHigh) begin
        stateNext = ST_IDLE;
      end else if (enRise) begin
        stateNext    = ST_BUSY;
        strb.capData = 1'b1;
      end
      ST_BUSY: if (cnt == LAST) begin
        stateNext   = ST_IDLE;
        strb.commit = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (strb.capData) cnt <= '0;
      else if (state == ST_BUSY) cnt <= cnt + 1'b1;
    end
  end

  assign busy  = (state == ST_BUSY);
  assign armed = (state == ST_ARMED);
endmodule

// File: rtl/bsw_datapath.sv
module bsw_datapath
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bswStrobes_t       strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        store [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      dataOut <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (strb.capAddr) addrReg <= addrIn;
      if (strb.capData) dataReg <= dataIn;
      if (strb.commit) store[addrReg] <= dataReg;
      dataOut <= busy ? {~dataReg[7], 7'b0} : store[addrIn];
    end
  end
endmodule

// File: rtl/byte_store_writer.sv
module byte_store_writer
  import bsw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              wrEnN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              busy
);
  logic [NUM_STROBES-1:0] rawN, lvlN, fall, rise;
  bswStrobes_t strb;
  logic armedW, oeLowW;

  assign rawN[IDX_CE] = chipEnN;
  assign rawN[IDX_WE] = wrEnN;
  assign rawN[IDX_OE] = outEnN;
  assign oeLowW = ~lvlN[IDX_OE];

  bsw_sync #(.WIDTH(NUM_STROBES)) u_sync (
    .clk(clk), .rstN(rstN), .rawN(rawN), .lvlN(lvlN), .fall(fall), .rise(rise)
  );

  bsw_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lvlN(lvlN), .fall(fall), .rise(rise),
    .strb(strb), .busy(busy), .armed(armedW)
  );

  bsw_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker #(
  parameter int PROG_CYCLES = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       armed,
  input logic       oeLow,
  input logic [7:0] dataOut
);
  int unsigned runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else runLen <= busy ? runLen + 1 : 0;
  end

  // R5: busy lasts exactly PROG_CYCLES cycles
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(busy)) |-> (runLen == PROG_CYCLES));

  // R5: busy never exceeds PROG_CYCLES cycles
  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < PROG_CYCLES));

  // R6: polling status has low bits cleared
  a_r6_status_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> (dataOut[6:0] == 7'd0));

  // R2: busy only follows an open window
  a_r2_busy_from_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(armed));

  // R8: output enable low closes the window without programming
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (armed && oeLow) |=> (!armed && !busy));
endmodule

bind byte_store_writer bsw_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .armed(armedW),
  .oeLow(oeLowW), .dataOut(dataOut)
);

// File: tb/byte_store_writer_tb.sv
`timescale 1ns/1ps
module byte_store_writer_tb;
  localparam int AW   = 4;
  localparam int PROG = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEnN = 1'b1, wrEnN = 1'b1, outEnN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic busy;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  // reference model state
  logic [2:0] mS1 = '1, mS2 = '1, mP = '1;   // bit0 CE, bit1 WE, bit2 OE
  int mState = 0;                            // 0 idle, 1 window open, 2 programming
  int mCnt = 0;
  logic [AW-1:0] mAddr = '0;
  logic [7:0] mData = '0;
  logic [7:0] mMem [1<<AW];
  logic [7:0] mOut = '0;
  int busyRun = 0;

  always #2 clk = ~clk;

  byte_store_writer #(.ADDR_W(AW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .wrEnN(wrEnN), .outEnN(outEnN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [7:0] nOut;
    bit fallAny, riseAny;
    nOut = (mState == 2) ? {~mData[7], 7'b0} : mMem[addrIn];
    fallAny = (mP[0] && !mS2[0]) || (mP[1] && !mS2[1]);
    riseAny = (!mP[0] && mS2[0]) || (!mP[1] && mS2[1]);
    case (mState)
      0: if (fallAny && !mS2[0] && !mS2[1] && mS2[2]) begin
           mState = 1; mAddr = addrIn;
         end
      1: if (!mS2[2]) mState = 0;
         else if (riseAny) begin mState = 2; mData = dataIn; mCnt = 0; end
      default: if (mCnt == PROG - 1) begin mMem[mAddr] = mData; mState = 0; end
               else mCnt++;
    endcase
    mP = mS2; mS2 = mS1; mS1 = {outEnN, wrEnN, chipEnN};
    mOut = nOut;
    @(posedge clk);
    @(negedge clk);
    check(busy === (mState == 2), curReq, 32'(busy), 32'(mState == 2), "busy vs model");
    check(dataOut === mOut, curReq, 32'(dataOut), 32'(mOut), "dataOut vs model");
    if (busy) busyRun++;
    else if (busyRun > 0) begin
      check(busyRun == PROG, "R5", busyRun, PROG, "busy length");
      busyRun = 0;
    end
  endtask

  task automatic cycN(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && (busy || mState != 0); i++) cyc();
    cycN(2);
  endtask

  task automatic readBack(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    addrIn = a;
    cycN(2);
    check(dataOut === exp, tag, dataOut, exp, "stored byte");
  endtask

  // ceLast: chip enable falls later (captures address); ceFirstUp: chip enable rises first
  task automatic doWrite(input bit ceLast, input bit ceFirstUp, input logic [AW-1:0] a,
                         input logic [7:0] d, input bit finish);
    addrIn = a; dataIn = d;
    if (ceLast) wrEnN = 1'b0; else chipEnN = 1'b0;
    cycN(3);
    if (ceLast) chipEnN = 1'b0; else wrEnN = 1'b0;
    cycN(4);
    addrIn = ~a;                                 // R3: must not move the address
    cycN(2);
    if (ceFirstUp) chipEnN = 1'b1; else wrEnN = 1'b1;
    cycN(4);
    dataIn = ~d;                                 // R4: must not move the data
    cycN(2);
    chipEnN = 1'b1; wrEnN = 1'b1;
    cycN(5);
    check(busy === 1'b1, "R5", busy, 1, "busy during programming");
    check(dataOut === {~d[7], 7'b0}, "R6", dataOut, {~d[7], 7'b0}, "polling status");
    if (finish) waitIdle();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mMem[i] = '0;
    repeat (4) @(negedge clk);
    curReq = "R1";
    check(busy === 1'b0, "R1", busy, 0, "busy in reset");
    check(dataOut === 8'h00, "R1", dataOut, 0, "dataOut in reset");
    rstN = 1'b1;
    cyc();
    check(busy === 1'b0 && dataOut === 8'h00, "R1", {busy, dataOut}, 0, "after reset");
    readBack(4'd3, 8'h00, "R1");

    // write enable controls both edges
    curReq = "R3";
    doWrite(1'b0, 1'b0, 4'd3, 8'hA5, 1'b1);
    readBack(4'd3, 8'hA5, "R7");
    readBack(4'd12, 8'h00, "R3");

    // chip enable controls both edges
    curReq = "R4";
    doWrite(1'b1, 1'b1, 4'd9, 8'h3C, 1'b1);
    readBack(4'd9, 8'h3C, "R4");
    readBack(4'd6, 8'h00, "R10");

    // mixed control; same byte as the write-enable case
    curReq = "R10";
    doWrite(1'b1, 1'b0, 4'd2, 8'hA5, 1'b1);
    readBack(4'd2, 8'hA5, "R10");

    // abort by output enable inside the window
    curReq = "R8";
    addrIn = 4'd5; dataIn = 8'h5A;
    chipEnN = 1'b0; wrEnN = 1'b0;
    cycN(6);
    outEnN = 1'b0;
    cycN(4);
    wrEnN = 1'b1; chipEnN = 1'b1;
    cycN(4);
    outEnN = 1'b1;
    cycN(4);
    check(busy === 1'b0, "R8", busy, 0, "no programming after abort");
    readBack(4'd5, 8'h00, "R8");

    // abort and rising enable land in the same synchronized cycle
    addrIn = 4'd11; dataIn = 8'h99;
    chipEnN = 1'b0; wrEnN = 1'b0;
    cycN(6);
    outEnN = 1'b0; wrEnN = 1'b1;
    cycN(5);
    chipEnN = 1'b1; outEnN = 1'b1;
    cycN(5);
    check(busy === 1'b0, "R8", busy, 0, "abort wins over capture");
    readBack(4'd11, 8'h00, "R8");

    // enables fall while output enable is low
    curReq = "R2";
    addrIn = 4'd7; dataIn = 8'h42;
    outEnN = 1'b0;
    cycN(3);
    chipEnN = 1'b0; wrEnN = 1'b0;
    cycN(5);
    outEnN = 1'b1;
    cycN(5);
    wrEnN = 1'b1;
    cycN(5);
    chipEnN = 1'b1;
    cycN(4);
    check(busy === 1'b0, "R2", busy, 0, "no write without high output enable");
    readBack(4'd7, 8'h00, "R2");

    // strobes during programming are ignored
    curReq = "R9";
    doWrite(1'b0, 1'b1, 4'd1, 8'h11, 1'b0);
    addrIn = 4'd8; dataIn = 8'h77;
    chipEnN = 1'b0; wrEnN = 1'b0;
    cycN(4);
    wrEnN = 1'b1;
    cycN(4);
    chipEnN = 1'b1;
    waitIdle();
    readBack(4'd8, 8'h00, "R9");
    readBack(4'd1, 8'h11, "R9");

    // enables held low across the end of programming: no new write
    doWrite(1'b1, 1'b0, 4'd4, 8'h80, 1'b0);
    addrIn = 4'd13; dataIn = 8'hEE;
    chipEnN = 1'b0; wrEnN = 1'b0;
    waitIdle();
    cycN(4);
    wrEnN = 1'b1; chipEnN = 1'b1;
    cycN(6);
    check(busy === 1'b0, "R9", busy, 0, "no write without fresh falling enable");
    readBack(4'd13, 8'h00, "R9");
    readBack(4'd4, 8'h80, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule